// File: doc/BRIEF.md
# Multi-Precision Dot-Product Processing Element

This block is one processing element of a matrix engine. Each cycle it accepts a packed word of activations and a packed word of weights covering a vector of lanes. It forms the dot product of the two words in one of three low-precision formats, and adds that partial sum into a signed running accumulator.

The first format is a true signed-by-unsigned 4-bit multiply. The second is a multiplier-free ternary path, in which each 4-bit activation is added, subtracted or skipped according to a 2-bit weight code. The third is a binary path that counts agreeing bits with XNOR and a population count.

The format is latched only when the accumulator is cleared, so a whole dot product is always summed in one format. The accumulated value comes out of a register one cycle after the operands are presented. A result-valid flag marks each cycle in which a fresh partial sum was folded in.

Top module: `mpdp_pe`

## Requirements
- R1: After a synchronous active-low reset the accumulator output is 0, the result-valid flag is 0, and the latched format is the 4-bit integer format (code 00).
- R2: Format code 00: for lane k (0..7) the activation is the unsigned value act_i[4k+3:4k] and the weight is the two's-complement value wgt_i[4k+3:4k]; the partial sum is the sum of the eight lane products.
- R3: Format code 01 (ternary): the weight code of lane k is wgt_i[4k+1:4k]; code 01 adds the unsigned activation, code 11 subtracts it, and codes 00 and 10 skip it; wgt_i[4k+3:4k+2] has no effect.
- R4: Format code 10 (binary): lane k uses act_i[4k] and wgt_i[4k], where 1 means +1 and 0 means -1; the partial sum is 2*popcount(XNOR)-8, and all other operand bits have no effect.
- R5: Format code 11 is reserved and yields a partial sum of 0.
- R6: With vld_i high and clr_i low, the accumulator becomes the old value plus the partial sum, wrapping modulo 2^20; acc_o shows it in the next cycle.
- R7: With clr_i high and vld_i low, acc_o is 0 in the next cycle.
- R8: With clr_i and vld_i both high, the accumulator loads the partial sum of that cycle alone.
- R9: mode_i is sampled only in cycles with clr_i high, and that cycle already uses the new format; at all other times it has no effect.
- R10: With clr_i and vld_i both low, acc_o holds its value.
- R11: res_vld_o is high in exactly the cycles that follow a cycle with vld_i high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Operand format, sampled on clear |
| clr_i | input | 1 | Clear the accumulator and latch mode_i |
| vld_i | input | 1 | Operand words are valid this cycle |
| act_i | input | 32 | Eight packed 4-bit activation lanes |
| wgt_i | input | 32 | Eight packed 4-bit weight lanes |
| acc_o | output | 20 | Signed accumulated result |
| res_vld_o | output | 1 | acc_o holds a freshly accumulated value |

## Verification
The bench targets the extremes of the integer path: all activations at 15 against all weights at -8 and at +7. A design that treated weights as unsigned or activations as signed would give the wrong sign or magnitude there. It drives ternary lanes with codes 10 and junk in the upper weight bits, which a loose decoder would wrongly count. It also drives binary vectors that fully agree and fully disagree, where a missing offset shows up as 16 and 0 instead of +8 and -8.

It changes mode_i without a clear to catch a design that switches formats mid-sum. It raises clear together with valid to catch one that drops the new partial sum. Finally, it accumulates the positive maximum about seven hundred times to expose any saturation or truncation at the 20-bit wrap.

// File: rtl/mpdp_pkg.sv
// Shared types and constants for the multi-precision dot-product PE.
// Assumes nothing beyond IEEE 1800-2017.
package mpdp_pkg;

    // Operand format codes; the values are visible at the mode_i port.
    typedef enum logic [1:0] {
        FMT_INT4 = 2'b00,
        FMT_TERN = 2'b01,
        FMT_BIN  = 2'b10,
        FMT_RSVD = 2'b11
    } fmt_e;

    // Bits per lane in the packed operand words.
    localparam int unsigned LANE_BITS = 4;

endpackage

// File: rtl/mpdp_lane_int4.sv
// One lane of the integer path: unsigned 4-bit activation times signed
// 4-bit weight. Assumes the product fits the 9-bit signed output.
module mpdp_lane_int4 (
    input  logic [3:0]        act_i,
    input  logic [3:0]        wgt_i,
    output logic signed [8:0] prod_o
);
    logic signed [4:0] act_s;
    logic signed [3:0] wgt_s;

    // Widen activation with a zero sign bit, multiply as signed.
    always_comb begin
        act_s  = $signed({1'b0, act_i});
        wgt_s  = $signed(wgt_i);
        prod_o = 9'(act_s * wgt_s);
    end
endmodule

// File: rtl/mpdp_lane_tern.sv
// One lane of the ternary path: add, subtract or skip the activation
// by a 2-bit weight code. No multiplier. Codes 00 and 10 both skip.
module mpdp_lane_tern (
    input  logic [3:0]        act_i,
    input  logic [1:0]        code_i,
    output logic signed [5:0] term_o
);
    logic signed [5:0] act_s;

    // Select the signed contribution of this lane.
    always_comb begin
        act_s = $signed({2'b00, act_i});
        unique case (code_i)
            2'b01:   term_o = act_s;
            2'b11:   term_o = -act_s;
            default: term_o = '0;
        endcase
    end
endmodule

// File: rtl/mpdp_bin_dot.sv
// Binary dot product of NLANE one-bit values (1 = +1, 0 = -1):
// 2*popcount(XNOR) - NLANE. Assumes PS_W holds +/-NLANE.
module mpdp_bin_dot #(
    parameter int unsigned NLANE = 8,
    parameter int unsigned PS_W  = 12
) (
    input  logic [NLANE-1:0]         a_i,
    input  logic [NLANE-1:0]         b_i,
    output logic signed [PS_W-1:0]   ps_o
);
    localparam int unsigned CNT_W = $clog2(NLANE + 1);

    logic [NLANE-1:0] agree;
    logic [CNT_W-1:0] cnt;

    // Count agreeing lanes, then map the count onto a signed sum.
    always_comb begin
        agree = ~(a_i ^ b_i);
        cnt   = '0;
        for (int k = 0; k < NLANE; k++) begin
            cnt = cnt + CNT_W'(agree[k]);
        end
        ps_o = $signed({{(PS_W-CNT_W-1){1'b0}}, cnt, 1'b0})
             - $signed(PS_W'(NLANE));
    end
endmodule

// File: rtl/mpdp_pe.sv
// Multi-precision dot-product processing element.
// Per cycle: one packed activation word and one packed weight word of
// NLANE lanes; the partial sum of the latched format is added to a
// wrapping signed accumulator. The format is latched only on clear.
// Assumes callers keep operand words stable around the clock edge.
module mpdp_pe
    import mpdp_pkg::*;
#(
    parameter int unsigned NLANE = 8,
    parameter int unsigned ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode_i,
    input  logic                    clr_i,
    input  logic                    vld_i,
    input  logic [NLANE*LANE_BITS-1:0] act_i,
    input  logic [NLANE*LANE_BITS-1:0] wgt_i,
    output logic signed [ACC_W-1:0] acc_o,
    output logic                    res_vld_o
);
    localparam int unsigned PS_W = 9 + $clog2(NLANE);
    localparam int signed   TERN_MAX = 15 * NLANE;

    fmt_e                  fmt_q;
    fmt_e                  fmt_eff;
    logic signed [8:0]     int_prod [NLANE];
    logic signed [5:0]     tern_term[NLANE];
    logic [NLANE-1:0]      bin_a;
    logic [NLANE-1:0]      bin_w;
    logic signed [PS_W-1:0] int_sum;
    logic signed [PS_W-1:0] tern_sum;
    logic signed [PS_W-1:0] bin_sum;
    logic signed [PS_W-1:0] part_sum;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_d;
    logic                  rv_q;

    // Per-lane datapaths for the integer and ternary formats.
    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        mpdp_lane_int4 u_int (
            .act_i  (act_i[k*LANE_BITS +: 4]),
            .wgt_i  (wgt_i[k*LANE_BITS +: 4]),
            .prod_o (int_prod[k])
        );
        mpdp_lane_tern u_tern (
            .act_i  (act_i[k*LANE_BITS +: 4]),
            .code_i (wgt_i[k*LANE_BITS +: 2]),
            .term_o (tern_term[k])
        );
        assign bin_a[k] = act_i[k*LANE_BITS];
        assign bin_w[k] = wgt_i[k*LANE_BITS];
    end

    mpdp_bin_dot #(.NLANE(NLANE), .PS_W(PS_W)) u_bin (
        .a_i  (bin_a),
        .b_i  (bin_w),
        .ps_o (bin_sum)
    );

    // Reduce lane results of the integer and ternary paths.
    always_comb begin
        int_sum  = '0;
        tern_sum = '0;
        for (int k = 0; k < NLANE; k++) begin
            int_sum  = int_sum  + PS_W'(int_prod[k]);
            tern_sum = tern_sum + PS_W'(tern_term[k]);
        end
    end

    // Pick the format: a clear cycle already uses the incoming mode.
    always_comb begin
        fmt_eff = clr_i ? fmt_e'(mode_i) : fmt_q;
        unique case (fmt_eff)
            FMT_INT4: part_sum = int_sum;
            FMT_TERN: part_sum = tern_sum;
            FMT_BIN:  part_sum = bin_sum;
            default:  part_sum = '0;
        endcase
    end

    // Next accumulator value from clear and valid.
    always_comb begin
        unique case ({clr_i, vld_i})
            2'b11:   acc_d = ACC_W'(part_sum);
            2'b10:   acc_d = '0;
            2'b01:   acc_d = acc_q + ACC_W'(part_sum);
            default: acc_d = acc_q;
        endcase
    end

    // State registers: format, accumulator, result-valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= FMT_INT4;
            acc_q <= '0;
            rv_q  <= 1'b0;
        end else begin
            if (clr_i) fmt_q <= fmt_e'(mode_i);
            acc_q <= acc_d;
            rv_q  <= vld_i;
        end
    end

    assign acc_o     = acc_q;
    assign res_vld_o = rv_q;

    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !vld_i) |=> (acc_o == '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !vld_i) |=> $stable(acc_o));

    // R11
    res_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> res_vld_o);

    // R11
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !res_vld_o);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> $stable(fmt_q));

    // R4
    bin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_sum <= $signed(PS_W'(NLANE))) && (bin_sum >= -$signed(PS_W'(NLANE)))
        && (bin_sum[0] == PS_W'(NLANE) % 2 != 0));

    // R3
    tern_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tern_sum <= $signed(PS_W'(TERN_MAX))) && (tern_sum >= -$signed(PS_W'(TERN_MAX))));

    // R8
    clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && vld_i) |=> (acc_o == ACC_W'($past(part_sum))));
endmodule

// File: tb/mpdp_pe_tb.sv
// Scoreboard bench: drive() models each cycle and queues expected
// results; a negedge monitor pops them when res_vld_o is high.
module mpdp_pe_tb;
    localparam int NL = 8;
    localparam int AW = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode_i = 2'b00;
    logic            clr_i = 1'b0;
    logic            vld_i = 1'b0;
    logic [NL*4-1:0] act_i = '0;
    logic [NL*4-1:0] wgt_i = '0;
    logic signed [AW-1:0] acc_o;
    logic            res_vld_o;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] m_acc = '0;
    logic [1:0]    m_mode = 2'b00;
    logic [AW-1:0] exp_q[$];
    string         tag_q[$];
    bit            done = 1'b0;

    mpdp_pe u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .clr_i(clr_i),
        .vld_i(vld_i), .act_i(act_i), .wgt_i(wgt_i),
        .acc_o(acc_o), .res_vld_o(res_vld_o)
    );

    always #5 clk = ~clk;

    // Partial sum from the requirement text (R2..R5).
    function automatic int ref_ps(input logic [1:0] m,
                                  input logic [NL*4-1:0] a,
                                  input logic [NL*4-1:0] w);
        int s = 0;
        for (int k = 0; k < NL; k++) begin
            int av = int'(a[4*k +: 4]);
            case (m)
                2'b00: s += av * int'($signed(w[4*k +: 4]));
                2'b01: begin
                    if (w[4*k +: 2] == 2'b01) s += av;
                    else if (w[4*k +: 2] == 2'b11) s -= av;
                end
                2'b10: s += (a[4*k] == w[4*k]) ? 1 : -1;
                default: ;
            endcase
        end
        return s;
    endfunction

    task automatic drive(input logic [1:0] m, input logic c, input logic v,
                         input logic [NL*4-1:0] a, input logic [NL*4-1:0] w,
                         input string tag);
        logic [1:0] eff;
        int ps;
        @(negedge clk);
        mode_i = m; clr_i = c; vld_i = v; act_i = a; wgt_i = w;
        eff = c ? m : m_mode;
        if (c) m_mode = m;
        ps = ref_ps(eff, a, w);
        if (c) m_acc = v ? AW'(ps) : '0;
        else if (v) m_acc = m_acc + AW'(ps);
        if (v) begin
            exp_q.push_back(m_acc);
            tag_q.push_back(tag);
        end
    endtask

    // Idle one cycle and compare acc_o to the model (result of last drive).
    task automatic check_acc(input string tag);
        @(negedge clk);
        clr_i = 1'b0; vld_i = 1'b0;
        checks++;
        if (acc_o !== $signed(m_acc)) begin
            errors++;
            $display("FAIL %s: acc_o=%0d expected=%0d", tag, acc_o, $signed(m_acc));
        end
    endtask

    // Monitor: pop one expected value for every flagged result.
    always @(negedge clk) begin
        if (rst_n && res_vld_o && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11: res_vld_o=1 expected=0 (no queued result)");
            end else begin
                logic [AW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (acc_o !== $signed(e)) begin
                    errors++;
                    $display("FAIL %s: acc_o=%0d expected=%0d", t, acc_o, $signed(e));
                end
            end
        end
    end

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run=hung expected=finished");
        finish_run();
    end

    function automatic logic [NL*4-1:0] rep(input logic [3:0] n);
        return {NL{n}};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state observed while reset is held.
        checks++;
        if (acc_o !== '0 || res_vld_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: acc_o=%0d res_vld_o=%0b expected=0/0", acc_o, res_vld_o);
        end
        rst_n = 1'b1;
        // R1: reset format is INT4 although mode_i asks for binary.
        drive(2'b10, 1'b0, 1'b1, rep(4'd3), rep(4'hE), "R1");
        check_acc("R1");
        // R2: extremes of the integer path.
        drive(2'b00, 1'b1, 1'b1, rep(4'd15), rep(4'h8), "R2");
        drive(2'b00, 1'b0, 1'b1, rep(4'd15), rep(4'h7), "R2");
        drive(2'b00, 1'b0, 1'b1, 32'h7654_3210, 32'h89AB_CDEF, "R2");
        check_acc("R2");
        check_acc("R10");
        // R8: clear with valid loads the partial sum.
        drive(2'b00, 1'b1, 1'b1, 32'h1111_1111, 32'h2222_2222, "R8");
        // R7: clear alone zeroes.
        drive(2'b00, 1'b1, 1'b0, rep(4'd9), rep(4'd9), "R7");
        check_acc("R7");
        // R3: ternary codes with junk in upper weight bits.
        drive(2'b01, 1'b1, 1'b1, rep(4'd9), 32'hD9E5_C1F2, "R3");
        drive(2'b01, 1'b0, 1'b1, 32'hFEDC_BA98, 32'h1357_9BDF, "R3");
        drive(2'b01, 1'b0, 1'b1, rep(4'd15), rep(4'hA), "R3");
        check_acc("R3");
        // R4: binary full agree, full disagree, mixed with junk bits.
        drive(2'b10, 1'b1, 1'b1, rep(4'hF), rep(4'h1), "R4");
        drive(2'b10, 1'b0, 1'b1, rep(4'hE), rep(4'h1), "R4");
        drive(2'b10, 1'b0, 1'b1, 32'hA5A5_3C3C, 32'h1234_5678, "R4");
        check_acc("R4");
        // R9: mode change without clear is ignored.
        drive(2'b00, 1'b0, 1'b1, rep(4'd15), rep(4'h7), "R9");
        check_acc("R9");
        // R5: reserved format adds nothing.
        drive(2'b11, 1'b1, 1'b1, rep(4'd15), rep(4'h7), "R5");
        drive(2'b00, 1'b0, 1'b1, rep(4'd15), rep(4'h7), "R5");
        check_acc("R5");
        // R6: wrap of the 20-bit accumulator.
        drive(2'b00, 1'b1, 1'b1, rep(4'd15), rep(4'h7), "R6");
        for (int i = 0; i < 700; i++)
            drive(2'b00, 1'b0, 1'b1, rep(4'd15), rep(4'h7), "R6");
        check_acc("R6");
        // R6/R9/R11: random traffic across formats.
        for (int i = 0; i < 400; i++)
            drive(2'($urandom_range(0, 3)), ($urandom_range(0, 9) == 0),
                  ($urandom_range(0, 3) != 0), $urandom, $urandom, "R6");
        check_acc("R6");
        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11: pending=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule